// File: doc/BRIEF.md
# Oscillator Warm-up and Clock-Source Controller

This block supervises the clock sources of a small microcontroller: a main crystal, a 32 kHz sub-oscillator and an internal RC oscillator. Each of the two crystal sources has its own warm-up counter. The counter advances on ticks from the oscillator being warmed and raises a ready flag once a length chosen by an option input has been reached. Software writes a small control word that holds four bits: run-from-RC, resume-from-RC, crystal-off and sub-off. The block reports the control bits back, together with both ready flags and the sleep state.

The block also enforces the clock interlocks. The CPU cannot be moved onto a crystal that is still warming up. The crystal can only be switched off while the CPU runs from RC. On wake from power-down, the resume bit chooses one of two behaviours. Either the CPU restarts at once on RC, or it is held on the crystal until that crystal has warmed up again. A watchdog reset leaves the clock-choice bits alone. A power-on or pin reset clears them.

Top module: `osc_clk_ctrl`

## Requirements
- R1: After power-on/pin reset `xt_ready`=1, `sub_ready`=0, `use_rc`=0, `cpu_hold`=0, `asleep`=0 and all status bits read 0. The sub-oscillator warm-up starts counting as soon as reset is released.
- R2: A crystal warm-up completes after XT_SHORT_CNT ticks on `xt_tick` when `opt_xt_long`=0, or after XT_LONG_CNT ticks when it is 1. `xt_ready` rises on the edge that takes the last tick. The first tick that counts is on the edge after the restart edge.
- R3: The sub-oscillator warm-up takes SUB_SHORT_CNT ticks on `sub_tick` when `opt_sub_long`=0, or SUB_LONG_CNT ticks when it is 1. Writing sub-off=1 clears `sub_ready` on the write edge. Writing it back to 0 restarts the count.
- R4: A write of crystal-off=1 takes effect only when `use_rc` is 1 before the write. Otherwise `st_xt_off` stays 0 and `xt_ready` keeps its value.
- R5: An accepted crystal-off=1 clears `xt_ready` on the write edge. A later write of crystal-off=0 restarts the crystal warm-up from zero.
- R6: A write with run-from-RC=0 while `use_rc`=1 and `xt_ready`=0 is blocked, and `use_rc` stays 1. With `xt_ready`=1 the write is accepted. Writing run-from-RC=1 is always accepted.
- R7: Entering power-down stops the crystal and clears `xt_ready`. A wake with resume-from-RC=1 sets `use_rc`=1 on the wake edge without asserting `cpu_hold`, and restarts the crystal warm-up if crystal-off is 0.
- R8: A wake with resume-from-RC=0 forces `use_rc`=0, clears crystal-off and restarts the crystal warm-up. It asserts `cpu_hold` from the wake edge, and `cpu_hold` drops in the same cycle that `xt_ready` rises.
- R9: `wdt_rst` leaves the run-from-RC and resume-from-RC bits unchanged. It ends any sleep or hold state, so `cpu_hold` reads 0 after it.
- R10: A crystal restart issued while a warm-up is already counting starts the count from zero. The full length is then needed again.
- R11: Register writes are ignored in a cycle with `wdt_rst`=1 and while `cpu_hold`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on / pin reset, active low, asynchronous |
| wdt_rst | input | 1 | Watchdog reset pulse, synchronous |
| wr_en | input | 1 | Control word write strobe |
| wr_rc_run | input | 1 | Write data: run CPU from RC |
| wr_resume_rc | input | 1 | Write data: resume from RC after power-down |
| wr_xt_off | input | 1 | Write data: crystal off |
| wr_sub_off | input | 1 | Write data: sub-oscillator off |
| opt_xt_long | input | 1 | Crystal warm-up option, 1 = long count |
| opt_sub_long | input | 1 | Sub-oscillator warm-up option, 1 = long count |
| xt_tick | input | 1 | One-cycle tick per crystal clock |
| sub_tick | input | 1 | One-cycle tick per sub-oscillator clock |
| pd_enter | input | 1 | Power-down entry event |
| wake | input | 1 | Wake event from power-down |
| use_rc | output | 1 | Clock select: 1 = RC, 0 = crystal |
| cpu_hold | output | 1 | CPU held until the crystal is ready |
| xt_ready | output | 1 | Crystal warm-up complete |
| sub_ready | output | 1 | Sub-oscillator warm-up complete |
| st_xt_off | output | 1 | Status: crystal-off bit |
| st_sub_off | output | 1 | Status: sub-off bit |
| st_resume_rc | output | 1 | Status: resume-from-RC bit |
| asleep | output | 1 | In power-down |

## Verification
The bench targets warm-up counts that are off by one. A counter that ignored the option input, took the restart-edge tick, or kept its old count on a mid-count restart would raise a ready flag one or more cycles early. The bench also hits the two interlocks in the order software might try them: switching off the crystal while running on it, and selecting the crystal before it is ready. A design without these interlocks would leave the CPU on a dead clock. Both wake paths are checked. The hold-until-ready path is checked for a hold that drops late, for writes accepted during the hold, and for a crystal left disabled, which would hang the hold forever. A watchdog pulse that carries a write is checked for clearing, or accepting, the clock-choice bits.

// File: rtl/osc_pkg.sv
package osc_pkg;

  typedef struct packed {
    logic rc_run;
    logic resume_rc;
    logic xt_off;
    logic sub_off;
  } osc_ctl_t;

  // warm-up length picked by the option input
  function automatic int warm_limit(input logic opt_long, input int short_c, input int long_c);
    return opt_long ? long_c : short_c;
  endfunction

  // width of a counter that must hold values below max_c
  function automatic int cnt_width(input int max_c);
    return (max_c < 2) ? 1 : $clog2(max_c + 1);
  endfunction

endpackage

// File: rtl/osc_warmup.sv
module osc_warmup #(
  parameter int SHORT_CNT  = 4096,
  parameter int LONG_CNT   = 65536,
  parameter bit INIT_READY = 1'b0,
  parameter bit INIT_RUN   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic halt,
  input  logic tick,
  input  logic opt_long,
  output logic ready,
  output logic running,
  output logic done_evt
);
  localparam int MAXC = (LONG_CNT > SHORT_CNT) ? LONG_CNT : SHORT_CNT;
  localparam int CW   = osc_pkg::cnt_width(MAXC);

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          rdy_q;
  int            lim_i;
  logic          count_evt;

  assign lim_i     = osc_pkg::warm_limit(opt_long, SHORT_CNT, LONG_CNT);
  assign count_evt = run_q & tick & ~restart & ~halt;
  assign done_evt  = count_evt & ((int'(cnt_q) + 1) >= lim_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= INIT_RUN;
      rdy_q <= INIT_READY;
    end else if (restart) begin
      cnt_q <= '0;
      run_q <= 1'b1;
      rdy_q <= 1'b0;
    end else if (halt) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      rdy_q <= 1'b0;
    end else if (done_evt) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      rdy_q <= 1'b1;
    end else if (count_evt) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready   = rdy_q;
  assign running = run_q;

  // R10: a restart always leaves the flag low for a fresh count
  p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !ready);
  // R5: stopping the oscillator drops its ready flag
  p_halt_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !restart) |=> !ready);
  // R2: ready only appears after a counted tick
  p_ready_by_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(run_q && tick));
  // R2: the counter never runs past the longest length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (int'(cnt_q) < MAXC));
endmodule

// File: rtl/osc_ctl_regs.sv
module osc_ctl_regs (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_rst,
  input  logic              wr_en,
  input  osc_pkg::osc_ctl_t wr,
  input  logic              pd_enter,
  input  logic              wake,
  input  logic              xt_ready,
  output osc_pkg::osc_ctl_t ctl,
  output logic              asleep,
  output logic              cpu_hold,
  output logic              wake_evt,
  output logic              xt_restart,
  output logic              xt_halt,
  output logic              sub_restart,
  output logic              sub_halt
);
  osc_pkg::osc_ctl_t ctl_q;
  logic asleep_q, hold_q;
  logic wr_ok, pd_evt, xt_set_ok, xt_clr;

  assign cpu_hold  = hold_q & ~xt_ready;
  assign wr_ok     = wr_en & ~wdt_rst & ~cpu_hold;
  assign wake_evt  = wake & asleep_q & ~wdt_rst;
  assign pd_evt    = pd_enter & ~asleep_q & ~wdt_rst & ~cpu_hold;
  assign xt_set_ok = wr_ok & ~wake_evt & wr.xt_off & ctl_q.rc_run & ~ctl_q.xt_off;
  assign xt_clr    = wr_ok & ~wake_evt & ~wr.xt_off & ctl_q.xt_off;

  assign xt_restart  = xt_clr | (wake_evt & (~ctl_q.resume_rc | ~ctl_q.xt_off));
  assign xt_halt     = xt_set_ok | pd_evt | asleep_q;
  assign sub_restart = wr_ok & ~wake_evt & ~wr.sub_off & ctl_q.sub_off;
  assign sub_halt    = wr_ok & ~wake_evt & wr.sub_off & ~ctl_q.sub_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wake_evt) begin
      ctl_q.rc_run <= ctl_q.resume_rc;
      if (!ctl_q.resume_rc) ctl_q.xt_off <= 1'b0;
    end else if (wr_ok) begin
      ctl_q.resume_rc <= wr.resume_rc;
      ctl_q.sub_off   <= wr.sub_off;
      ctl_q.rc_run    <= wr.rc_run | (ctl_q.rc_run & ~xt_ready);
      ctl_q.xt_off    <= wr.xt_off & (ctl_q.xt_off | ctl_q.rc_run);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q <= 1'b0;
      hold_q   <= 1'b0;
    end else if (wdt_rst) begin
      asleep_q <= 1'b0;
      hold_q   <= 1'b0;
    end else if (wake_evt) begin
      asleep_q <= 1'b0;
      hold_q   <= ~ctl_q.resume_rc;
    end else begin
      if (pd_evt) asleep_q <= 1'b1;
      if (hold_q && xt_ready) hold_q <= 1'b0;
    end
  end

  assign ctl    = ctl_q;
  assign asleep = asleep_q;

  p_xtoff_rc_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr.xt_off && !ctl_q.rc_run && !ctl_q.xt_off && !wake_evt) |=> !ctl_q.xt_off);
  p_sel_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !wr.rc_run && ctl_q.rc_run && !xt_ready && !wake_evt) |=> ctl_q.rc_run);
  p_wdt_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> (ctl_q.rc_run == $past(ctl_q.rc_run) && ctl_q.resume_rc == $past(ctl_q.resume_rc)));
  p_hold_on_xtal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hold |-> !ctl_q.rc_run);
  p_resume_rc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && ctl_q.resume_rc) |=> (ctl_q.rc_run && !cpu_hold));
  p_hold_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hold && !wdt_rst) |=> $stable(ctl_q.resume_rc) && $stable(ctl_q.sub_off));
endmodule

// File: rtl/osc_clk_ctrl.sv
module osc_clk_ctrl #(
  parameter int XT_SHORT_CNT  = 4096,
  parameter int XT_LONG_CNT   = 65536,
  parameter int SUB_SHORT_CNT = 1024,
  parameter int SUB_LONG_CNT  = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_rst,
  input  logic wr_en,
  input  logic wr_rc_run,
  input  logic wr_resume_rc,
  input  logic wr_xt_off,
  input  logic wr_sub_off,
  input  logic opt_xt_long,
  input  logic opt_sub_long,
  input  logic xt_tick,
  input  logic sub_tick,
  input  logic pd_enter,
  input  logic wake,
  output logic use_rc,
  output logic cpu_hold,
  output logic xt_ready,
  output logic sub_ready,
  output logic st_xt_off,
  output logic st_sub_off,
  output logic st_resume_rc,
  output logic asleep
);
  osc_pkg::osc_ctl_t wr_word, ctl;
  logic wake_evt, xt_restart, xt_halt, sub_restart, sub_halt;
  logic xt_run, sub_run, xt_done_evt, sub_done_evt;

  assign wr_word = '{rc_run: wr_rc_run, resume_rc: wr_resume_rc,
                     xt_off: wr_xt_off, sub_off: wr_sub_off};

  osc_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .wr_en(wr_en), .wr(wr_word),
    .pd_enter(pd_enter), .wake(wake), .xt_ready(xt_ready), .ctl(ctl),
    .asleep(asleep), .cpu_hold(cpu_hold), .wake_evt(wake_evt),
    .xt_restart(xt_restart), .xt_halt(xt_halt),
    .sub_restart(sub_restart), .sub_halt(sub_halt)
  );

  osc_warmup #(.SHORT_CNT(XT_SHORT_CNT), .LONG_CNT(XT_LONG_CNT),
               .INIT_READY(1'b1), .INIT_RUN(1'b0)) u_xt_warm (
    .clk(clk), .rst_n(rst_n), .restart(xt_restart), .halt(xt_halt),
    .tick(xt_tick), .opt_long(opt_xt_long), .ready(xt_ready),
    .running(xt_run), .done_evt(xt_done_evt)
  );

  osc_warmup #(.SHORT_CNT(SUB_SHORT_CNT), .LONG_CNT(SUB_LONG_CNT),
               .INIT_READY(1'b0), .INIT_RUN(1'b1)) u_sub_warm (
    .clk(clk), .rst_n(rst_n), .restart(sub_restart), .halt(sub_halt),
    .tick(sub_tick), .opt_long(opt_sub_long), .ready(sub_ready),
    .running(sub_run), .done_evt(sub_done_evt)
  );

  assign use_rc       = ctl.rc_run;
  assign st_xt_off    = ctl.xt_off;
  assign st_sub_off   = ctl.sub_off;
  assign st_resume_rc = ctl.resume_rc;

  // R6: the CPU leaves RC only onto a ready crystal, or through a held wake
  p_sel_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(use_rc) |-> ($past(xt_ready) || $past(wake_evt)));
  // R5: a disabled crystal never reports ready or counts
  p_off_not_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_xt_off |-> (!xt_ready && !xt_run));
  // R3: a disabled sub-oscillator never reports ready
  p_sub_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_sub_off |-> (!sub_ready && !sub_run));
  // R8: the hold ends exactly when the crystal finishes warming
  p_hold_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_hold) && !$past(wdt_rst)) |-> $past(xt_done_evt));
endmodule

// File: tb/tb_osc_clk_ctrl.sv
module tb_osc_clk_ctrl;
  localparam int XS = 20, XL = 60, SS = 10, SL = 40;

  logic clk = 0, rst_n = 0, wdt_rst = 0, wr_en = 0;
  logic wr_rc_run = 0, wr_resume_rc = 0, wr_xt_off = 0, wr_sub_off = 0;
  logic opt_xt_long = 0, opt_sub_long = 0, xt_tick = 1, sub_tick = 1;
  logic pd_enter = 0, wake = 0;
  logic use_rc, cpu_hold, xt_ready, sub_ready, st_xt_off, st_sub_off, st_resume_rc, asleep;

  osc_clk_ctrl #(.XT_SHORT_CNT(XS), .XT_LONG_CNT(XL),
                 .SUB_SHORT_CNT(SS), .SUB_LONG_CNT(SL)) dut (.*);

  always #2.5 clk = ~clk;

  int cyc = 0, total = 0, bad = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; int sig; int exp; string req; } item_t;
  item_t sb_q[$];

  function automatic int sig_val(int s);
    case (s)
      0: return int'(xt_ready);
      1: return int'(sub_ready);
      2: return int'(use_rc);
      3: return int'(cpu_hold);
      4: return int'(st_xt_off);
      5: return int'(st_sub_off);
      6: return int'(st_resume_rc);
      default: return int'(asleep);
    endcase
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].at == cyc) begin
        total++;
        if (sig_val(sb_q[i].sig) != sb_q[i].exp) begin
          bad++;
          $display("FAIL %s: signal %0d at cycle %0d actual=%0d expected=%0d",
                   sb_q[i].req, sb_q[i].sig, cyc, sig_val(sb_q[i].sig), sb_q[i].exp);
        end
        sb_q.delete(i);
      end
    end
  end

  task automatic expect_at(int d, int s, int e, string req);
    item_t it;
    it.at = cyc + d; it.sig = s; it.exp = e; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(bit rc, bit res, bit xo, bit so);
    wr_en = 1; wr_rc_run = rc; wr_resume_rc = res; wr_xt_off = xo; wr_sub_off = so;
    step(1);
    wr_en = 0;
  endtask

  task automatic pulse_pd();  pd_enter = 1; step(1); pd_enter = 0; endtask
  task automatic pulse_wake(); wake = 1; step(1); wake = 0; endtask

  // watchdog
  initial begin
    while (cyc < 5000 && !done) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 5000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    expect_at(1, 0, 1, "R1"); expect_at(1, 1, 0, "R1"); expect_at(1, 2, 0, "R1");
    expect_at(1, 3, 0, "R1"); expect_at(1, 4, 0, "R1"); expect_at(1, 7, 0, "R1");
    step(3);
    rst_n = 1;
    // R1/R3: sub warm-up starts at reset release, short option
    expect_at(SS - 1, 1, 0, "R3"); expect_at(SS, 1, 1, "R3");
    step(SS + 2);

    // R4: crystal off refused while on crystal
    expect_at(1, 4, 0, "R4"); expect_at(1, 0, 1, "R4");
    wr(0, 0, 1, 0);
    // R6: moving to RC always allowed
    expect_at(1, 2, 1, "R6");
    wr(1, 0, 0, 0);
    // R5: accepted off clears ready
    expect_at(1, 4, 1, "R5"); expect_at(1, 0, 0, "R5");
    wr(1, 0, 1, 0);
    // R6: crystal select blocked while not ready
    expect_at(1, 2, 1, "R6");
    wr(0, 0, 1, 0);
    // R5/R2: re-enable restarts short warm-up
    expect_at(XS, 0, 0, "R2"); expect_at(XS + 1, 0, 1, "R5");
    wr(1, 0, 0, 0);
    step(XS + 1);
    // R6: select crystal once ready
    expect_at(1, 2, 0, "R6");
    wr(0, 0, 0, 0);
    wr(1, 0, 0, 0);

    // R2: long option
    wr(1, 0, 1, 0);
    opt_xt_long = 1;
    expect_at(XL, 0, 0, "R2"); expect_at(XL + 1, 0, 1, "R2");
    wr(1, 0, 0, 0);
    step(XL + 1);
    opt_xt_long = 0;

    // R10: restart mid-count starts again from zero
    wr(1, 0, 1, 0);
    wr(1, 0, 0, 0);
    step(8);
    wr(1, 0, 1, 0);
    expect_at(XS, 0, 0, "R10"); expect_at(XS + 1, 0, 1, "R10");
    wr(1, 0, 0, 0);
    step(XS + 1);

    // R3: sub-off clears, re-enable with long option
    expect_at(1, 1, 0, "R3"); expect_at(1, 5, 1, "R3");
    wr(1, 0, 0, 1);
    opt_sub_long = 1;
    expect_at(SL, 1, 0, "R3"); expect_at(SL + 1, 1, 1, "R3");
    wr(1, 0, 0, 0);
    step(SL + 1);

    // R7: power-down then wake onto RC
    expect_at(1, 2, 0, "R7");
    wr(0, 1, 0, 0);
    expect_at(1, 7, 1, "R7"); expect_at(1, 0, 0, "R7");
    pulse_pd();
    step(3);
    expect_at(1, 2, 1, "R7"); expect_at(1, 3, 0, "R7"); expect_at(1, 7, 0, "R7");
    expect_at(XS, 0, 0, "R7"); expect_at(XS + 1, 0, 1, "R7");
    pulse_wake();
    step(XS + 1);

    // R8: wake with resume=0 holds on crystal, clears crystal-off
    expect_at(1, 4, 1, "R8");
    wr(1, 0, 1, 0);
    pulse_pd();
    step(2);
    expect_at(1, 3, 1, "R8"); expect_at(1, 2, 0, "R8"); expect_at(1, 4, 0, "R8");
    expect_at(XS, 3, 1, "R8"); expect_at(XS + 1, 3, 0, "R8"); expect_at(XS + 1, 0, 1, "R8");
    pulse_wake();
    // R11: write during hold ignored
    expect_at(1, 2, 0, "R11"); expect_at(1, 5, 0, "R11");
    wr(1, 0, 0, 1);
    step(XS + 1);

    // R9/R11: watchdog keeps choice bits and ignores a coincident write
    expect_at(1, 2, 1, "R9"); expect_at(1, 6, 1, "R9");
    wr(1, 1, 0, 0);
    wdt_rst = 1; wr_en = 1; wr_rc_run = 0; wr_resume_rc = 0; wr_xt_off = 0; wr_sub_off = 1;
    expect_at(1, 2, 1, "R9"); expect_at(1, 6, 1, "R9"); expect_at(1, 5, 0, "R11");
    step(1);
    wdt_rst = 0; wr_en = 0;

    // R9: watchdog ends a hold
    wr(1, 0, 0, 0);
    pulse_pd();
    step(2);
    pulse_wake();
    step(3);
    expect_at(1, 3, 0, "R9"); expect_at(1, 7, 0, "R9");
    wdt_rst = 1; step(1); wdt_rst = 0;

    step(XS + 5);
    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: pending items actual=%0d expected=%0d", sb_q.size(), 0);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule